// File: doc/BRIEF.md
# Down-Spread Modulation Profile Generator

This block produces the frequency-offset sequence that a fractional-N synthesizer needs to spread its output clock downward. It has two channels. The first serves a 100 MHz output: one control bit turns a fixed half-percent down-spread on or off. The second serves an 80 MHz output: a two-bit code picks one of three spread depths or no spread at all. Each channel emits a signed offset in hundredths of a percent of nominal frequency. A one-cycle strobe marks every point where the profile comes back to zero.

The profile is a symmetric triangle. It falls linearly from zero to the selected depth and then climbs linearly back. A shared prescaler counts `STEP_DIV` reference ticks per profile step, and a full triangle lasts `2**(HALF_LOG2+1)` steps. The integrator sets these two parameters so that one triangle spans 31.25 us, which is a 32 kHz modulation rate. Depth requests are sampled only at the top of a triangle, where the offset is zero, so the offset sequence never jumps. The downstream divider can apply the offset directly.

Top module: `ssc_profile_gen`

## Requirements
- R1: While `rst` is high (synchronous, active high) and afterwards until a spread request is sampled, both offsets are 0 and both strobes are 0. Both channels leave reset with their active depth set to off.
- R2: With `spread100_on` = 1 the 100 MHz channel uses a depth of 50 (units of 0.01 %, so -0.5 %). With `spread100_on` = 0 its depth is 0.
- R3: The 80 MHz depth is decoded from `sel80[1:0]`: 2'b00 gives 100 (-1.0 %), 2'b01 gives 0 (off), 2'b10 gives 50 (-0.5 %) and 2'b11 gives 75 (-0.75 %).
- R4: Inside a triangle, phase p runs from 0 to 2H-1, where H = 2**HALF_LOG2. The offset is -floor(D*q/H), where D is the active depth, q = p for p <= H and q = 2H-p otherwise. The offset therefore reaches -D at p = H.
- R5: The prescaler turns every `STEP_DIV` cycles that have `ref_tick` = 1 and `run_en` = 1 into one step. The phase advances by one per step, so each offset changes on the clock edge that ends the `STEP_DIV`-th such tick. A triangle lasts 2H steps.
- R6: An offset is never positive and never below minus its channel's largest depth (-50 for the 100 MHz channel, -100 for the 80 MHz channel).
- R7: A depth request is sampled only on a step taken at phase 0. A request changed during a triangle has no effect until that triangle has returned to zero. Between two steps the offset moves by no more than ceil(100/H)+1.
- R8: While a channel's active depth is 0, its phase stays at 0, its offset stays 0 and its strobe never fires.
- R9: The strobe of a channel is high for exactly one clock cycle, the cycle after the step that takes the phase from 2H-1 back to 0. The offset is 0 while the strobe is high.
- R10: While `run_en` = 0 no step is taken: the offsets, phases and prescaler count all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle reference tick feeding the step prescaler |
| run_en | input | 1 | Enables stepping. Low freezes both profiles |
| spread100_on | input | 1 | Spread request for the 100 MHz channel |
| sel80 | input | 2 | Depth code for the 80 MHz channel |
| ofs100 | output | OFS_W | Signed offset of the 100 MHz channel, 0.01 % units |
| wrap100 | output | 1 | Return-to-zero strobe of the 100 MHz channel |
| ofs80 | output | OFS_W | Signed offset of the 80 MHz channel, 0.01 % units |
| wrap80 | output | 1 | Return-to-zero strobe of the 80 MHz channel |

## Verification
Offsets are decoded combinationally from the phase and depth registers, so a new offset appears right after the edge that completes a step, with no further delay. The strobe is also registered on that same edge and falls at the following edge. The bench drives each tick on a falling edge and holds it high across exactly one rising edge. It samples after the second tick of every step, on the falling edge before the next rising edge, so the offset and the strobe of that step are both visible. A single extra tick is checked to leave the outputs unchanged, which shows that nothing changes before the step boundary.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    localparam int DEPTH_W = 8;

    typedef logic [DEPTH_W-1:0] depth_t;

    typedef enum logic [1:0] {
        SEL80_D100 = 2'b00,
        SEL80_OFF  = 2'b01,
        SEL80_D50  = 2'b10,
        SEL80_D75  = 2'b11
    } sel80_e;

    localparam depth_t DEPTH_NONE = depth_t'(0);
    localparam depth_t DEPTH_50   = depth_t'(50);
    localparam depth_t DEPTH_75   = depth_t'(75);
    localparam depth_t DEPTH_100  = depth_t'(100);

    // Depth for the channel with a plain on/off control
    function automatic depth_t depth_of_switch(input logic on);
        return on ? DEPTH_50 : DEPTH_NONE;
    endfunction

    // Depth for the channel with a two-bit code
    function automatic depth_t depth_of_code(input sel80_e code);
        depth_t d;
        case (code)
            SEL80_D100: d = DEPTH_100;
            SEL80_D50:  d = DEPTH_50;
            SEL80_D75:  d = DEPTH_75;
            default:    d = DEPTH_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ssc_step_div.sv
module ssc_step_div #(
    parameter int STEP_DIV = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic en_i,
    output logic step_o
);
    localparam int CNT_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             adv;

    assign adv    = tick_i & en_i;
    assign step_o = adv & (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ssc_tri_chan.sv
module ssc_tri_chan
    import ssc_pkg::*;
#(
    parameter int HALF_LOG2 = 4,
    parameter int OFS_W     = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_i,
    input  depth_t                  depth_req_i,
    output logic signed [OFS_W-1:0] offset_o,
    output logic                    wrap_o
);
    localparam int PH_W = HALF_LOG2 + 1;
    localparam int PW   = DEPTH_W + PH_W;
    localparam logic [PH_W-1:0] PH_LAST = {PH_W{1'b1}};

    logic [PH_W-1:0] ph_q;
    depth_t          depth_q;
    logic            wrap_q;
    logic [PH_W-1:0] pos;
    logic [PW-1:0]   prod;
    logic [PW-1:0]   mag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= '0;
            depth_q <= DEPTH_NONE;
            wrap_q  <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (step_i) begin
                if (ph_q == '0) begin
                    // top of triangle: only place a new depth is accepted
                    depth_q <= depth_req_i;
                    ph_q    <= (depth_req_i != DEPTH_NONE) ? PH_W'(1) : '0;
                end else begin
                    ph_q   <= ph_q + 1'b1;
                    wrap_q <= (ph_q == PH_LAST);
                end
            end
        end
    end

    // fold the phase into a distance from the top: 0..H..1
    assign pos  = ph_q[PH_W-1] ? (PH_W'(0) - ph_q) : ph_q;
    assign prod = PW'(depth_q) * PW'(pos);
    assign mag  = prod >> HALF_LOG2;

    assign offset_o = $signed(OFS_W'(0) - OFS_W'(mag));
    assign wrap_o   = wrap_q;
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
    import ssc_pkg::*;
#(
    parameter int STEP_DIV  = 25,
    parameter int HALF_LOG2 = 4,
    parameter int OFS_W     = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ref_tick,
    input  logic                    run_en,
    input  logic                    spread100_on,
    input  logic [1:0]              sel80,
    output logic signed [OFS_W-1:0] ofs100,
    output logic                    wrap100,
    output logic signed [OFS_W-1:0] ofs80,
    output logic                    wrap80
);
    localparam int N_CH = 2;

    logic   step;
    depth_t req [N_CH];
    logic signed [OFS_W-1:0] ofs [N_CH];
    logic   wrap [N_CH];

    ssc_step_div #(.STEP_DIV(STEP_DIV)) u_div (
        .clk    (clk),
        .rst    (rst),
        .tick_i (ref_tick),
        .en_i   (run_en),
        .step_o (step)
    );

    assign req[0] = depth_of_switch(spread100_on);
    assign req[1] = depth_of_code(sel80_e'(sel80));

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        ssc_tri_chan #(
            .HALF_LOG2 (HALF_LOG2),
            .OFS_W     (OFS_W)
        ) u_chan (
            .clk         (clk),
            .rst         (rst),
            .step_i      (step),
            .depth_req_i (req[c]),
            .offset_o    (ofs[c]),
            .wrap_o      (wrap[c])
        );
    end

    assign ofs100  = ofs[0];
    assign wrap100 = wrap[0];
    assign ofs80   = ofs[1];
    assign wrap80  = wrap[1];
endmodule

// File: rtl/ssc_profile_gen_chk.sv
module ssc_profile_gen_chk #(
    parameter int HALF_LOG2 = 4,
    parameter int OFS_W     = 12
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    run_en,
    input logic signed [OFS_W-1:0] ofs100,
    input logic                    wrap100,
    input logic signed [OFS_W-1:0] ofs80,
    input logic                    wrap80
);
    localparam int HALF      = 2 ** HALF_LOG2;
    localparam int MAX_DELTA = (100 + HALF - 1) / HALF + 1;

    AST_OFS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (ofs100 <= 0) && (ofs100 >= -50) && (ofs80 <= 0) && (ofs80 >= -100)); // R6

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (wrap100 |=> !wrap100) and (wrap80 |=> !wrap80)); // R9

    AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wrap100 -> ofs100 == 0) && (wrap80 -> ofs80 == 0)); // R9

    AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> ($stable(ofs100) && $stable(ofs80) && !wrap100 && !wrap80)); // R10

    AST_NO_JUMP: assert property (@(posedge clk) disable iff (rst)
        (int'(ofs100) - int'($past(ofs100)) <= MAX_DELTA) &&
        (int'($past(ofs100)) - int'(ofs100) <= MAX_DELTA) &&
        (int'(ofs80) - int'($past(ofs80)) <= MAX_DELTA) &&
        (int'($past(ofs80)) - int'(ofs80) <= MAX_DELTA)); // R7
endmodule

bind ssc_profile_gen ssc_profile_gen_chk #(
    .HALF_LOG2 (HALF_LOG2),
    .OFS_W     (OFS_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .ofs100  (ofs100),
    .wrap100 (wrap100),
    .ofs80   (ofs80),
    .wrap80  (wrap80)
);

// File: tb/ssc_profile_gen_bench.sv
module ssc_profile_gen_bench;
    localparam int STEP_DIV  = 2;
    localparam int HALF_LOG2 = 4;
    localparam int OFS_W     = 12;
    localparam int HALF      = 2 ** HALF_LOG2;
    localparam int CYC       = 2 * HALF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_tick = 1'b0;
    logic run_en = 1'b1;
    logic spread100_on = 1'b0;
    logic [1:0] sel80 = 2'b01;
    logic signed [OFS_W-1:0] ofs100, ofs80;
    logic wrap100, wrap80;

    int errors = 0;
    int checks = 0;

    // bench model state per channel (0: 100 MHz, 1: 80 MHz)
    int  ph_m  [2];
    int  dep_m [2];
    bit  wrap_m[2];

    always #4 clk = ~clk;

    ssc_profile_gen #(
        .STEP_DIV  (STEP_DIV),
        .HALF_LOG2 (HALF_LOG2),
        .OFS_W     (OFS_W)
    ) u_ssc_profile_gen (
        .clk          (clk),
        .rst          (rst),
        .ref_tick     (ref_tick),
        .run_en       (run_en),
        .spread100_on (spread100_on),
        .sel80        (sel80),
        .ofs100       (ofs100),
        .wrap100      (wrap100),
        .ofs80        (ofs80),
        .wrap80       (wrap80)
    );

    // {spread100_on, sel80, steps}
    localparam logic [10:0] VEC [6] = '{
        {1'b1, 2'b00, 8'd32},
        {1'b1, 2'b11, 8'd10},
        {1'b0, 2'b10, 8'd22},
        {1'b0, 2'b01, 8'd40},
        {1'b1, 2'b10, 8'd20},
        {1'b1, 2'b00, 8'd12}
    };

    function automatic int depth80(input logic [1:0] s);
        case (s)
            2'b00:   return 100;
            2'b10:   return 50;
            2'b11:   return 75;
            default: return 0;
        endcase
    endfunction

    function automatic int expect_ofs(input int c);
        int pos;
        pos = (ph_m[c] <= HALF) ? ph_m[c] : CYC - ph_m[c];
        return -((dep_m[c] * pos) / HALF);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(int'(ofs100) == expect_ofs(0), {req, " ofs100"}, int'(ofs100), expect_ofs(0));
        check(int'(ofs80)  == expect_ofs(1), {req, " ofs80"},  int'(ofs80),  expect_ofs(1));
        check(wrap100 == wrap_m[0], {req, " wrap100"}, int'(wrap100), int'(wrap_m[0]));
        check(wrap80  == wrap_m[1], {req, " wrap80"},  int'(wrap80),  int'(wrap_m[1]));
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            ph_m[c] = 0; dep_m[c] = 0; wrap_m[c] = 1'b0;
        end
    endtask

    task automatic model_step();
        int req;
        for (int c = 0; c < 2; c++) begin
            req = (c == 0) ? (spread100_on ? 50 : 0) : depth80(sel80);
            wrap_m[c] = 1'b0;
            if (ph_m[c] == 0) begin
                dep_m[c] = req;
                ph_m[c]  = (req != 0) ? 1 : 0;
            end else begin
                wrap_m[c] = (ph_m[c] == CYC - 1);
                ph_m[c]   = (ph_m[c] + 1) % CYC;
            end
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) ref_tick = 1'b1;
        @(negedge clk) ref_tick = 1'b0;
    endtask

    task automatic do_step(input string req);
        for (int t = 0; t < STEP_DIV; t++) pulse_tick();
        if (run_en) model_step();
        else begin
            wrap_m[0] = 1'b0; wrap_m[1] = 1'b0;
        end
        check_outputs(req);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R5: watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check_outputs("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_outputs("R1 after reset");

        // off codes: nothing moves, no strobes
        for (int k = 0; k < 3; k++) do_step("R8 idle off");

        // table of input patterns, each run for a number of steps
        for (int i = 0; i < 6; i++) begin
            spread100_on = VEC[i][10];
            sel80        = VEC[i][9:8];
            for (int k = 0; k < int'(VEC[i][7:0]); k++)
                do_step("R2 R3 R4 R7 R9 vector");
        end

        // run_en low: steps are ignored, outputs hold
        run_en = 1'b0;
        for (int k = 0; k < 4; k++) do_step("R10 frozen");
        run_en = 1'b1;
        do_step("R10 resume");

        // one tick short of a step changes nothing
        pulse_tick();
        wrap_m[0] = 1'b0; wrap_m[1] = 1'b0;
        check_outputs("R5 partial step");
        pulse_tick();
        model_step();
        check_outputs("R5 completed step");

        // reset in mid triangle clears both channels
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
        model_reset();
        check_outputs("R1 mid-run reset");

        // a full 80 MHz triangle at -0.75 % with the 100 MHz channel off
        spread100_on = 1'b0;
        sel80 = 2'b11;
        for (int k = 0; k < CYC + 1; k++) do_step("R3 R4 R9 depth75");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule